// File: doc/BRIEF.md
# Decode Stage Stall and Skid Controller

This block controls the flow of one thread through an instruction decode stage. Each cycle it takes a fetch group of up to `FW` slots and forwards up to `DW` live instructions to rename. It also tracks stall pulses from the rename, execute and commit stages and obeys squash indications from commit. When the stage cannot forward everything it is given, it parks the excess in a skid FIFO. It then tells fetch to hold off with a single block pulse.

When every stall source has released, the controller enters a draining phase. In that phase it serves rename from the skid FIFO, oldest first, and appends any fetch group still in flight behind the parked entries. Once a draining cycle empties the FIFO and brings in nothing new, it sends one unblock pulse to fetch and returns to passing fetch groups straight through. A squash from commit overrides everything else: it discards parked and arriving work. A core with several threads uses one instance per thread, and the instances are scanned in a fixed order.

Top module: `dec_stage_top`

## Requirements
- R1: After reset the stage is idle. `renameValid`, `fetchBlock` and `fetchUnblock` are all low, and every stall flag is clear.
- R2: Passing straight through, the stage forwards the live slots (`fetchValid` high and `fetchSquashed` low) in ascending slot order. Lane 0 gets the first live slot, and the valid lanes form a contiguous run from lane 0. Slots marked squashed are dropped and use no output lane.
- R3: Stall input bit 0 is rename, bit 1 is execute and bit 2 is commit. A `stageBlock` pulse sets the sticky flag for its source and a `stageUnblock` pulse clears it. Unblock wins if both pulses arrive in the same cycle. While any flag is set, the stage forwards nothing and parks every live arriving slot in the skid FIFO.
- R4: `fetchBlock` is a one-cycle pulse. It is raised only when the stage enters the blocked condition from a state that is neither blocked nor draining.
- R5: If a pass-through cycle has more than `DW` live slots, the first `DW` are forwarded. The remaining slots are parked in the skid FIFO, `fetchBlock` pulses, and the stage becomes blocked.
- R6: Once all flags are clear, a blocked stage drains. Each cycle it forwards up to `DW` parked entries, oldest first, and appends arriving live slots behind the parked entries. Nothing arriving is forwarded directly while draining.
- R7: `fetchUnblock` pulses in the draining cycle that leaves the FIFO empty with no new arrivals. From the next cycle on, fetch groups pass straight through.
- R8: A commit squash (`commitSquash` or `robSquashing`) outranks stall handling. In that cycle nothing is forwarded, the current fetch group and the skid FIFO are discarded, and the stage enters squashing. `fetchUnblock` pulses in that cycle only if the stage was blocked or draining.
- R9: While squash indications continue, the stage stays squashing and forwards nothing. In the first cycle with neither a squash nor a stall, the stage resumes and handles that cycle's fetch group as a pass-through cycle.
- R10: The skid FIFO holds `FETCH_DELAY*FW + DW` entries. All of them can be filled and then drained in order, and a push never exceeds that capacity.
- R11: A pass-through cycle with no valid slot forwards nothing and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchValid | input | FW | Slot holds an instruction |
| fetchSquashed | input | FW | Slot's instruction is already squashed |
| fetchInsts | input | FW*IW | Slot payloads, slot i at bits [i*IW +: IW] |
| stageBlock | input | 3 | Block pulses: bit0 rename, bit1 execute, bit2 commit |
| stageUnblock | input | 3 | Unblock pulses, same bit order |
| commitSquash | input | 1 | Squash request from commit |
| robSquashing | input | 1 | Commit's reorder buffer is still squashing |
| renameValid | output | DW | Lane carries an instruction to rename |
| renameInsts | output | DW*IW | Lane payloads, lane j at bits [j*IW +: IW] |
| fetchBlock | output | 1 | One-cycle request for fetch to stop |
| fetchUnblock | output | 1 | One-cycle release for fetch |

## Verification
The bench exercises pass-through with full, partial and sparse fetch groups, including groups with squashed holes. These show whether slots are compacted in order and whether bandwidth is charged only for live slots. Groups wider than the decode width check the overflow-to-skid path. Long stalls driven from each source check the sticky flags: they separate set, clear and same-cycle collisions, show whether a block pulse is repeated, and fill the FIFO to capacity and drain it across the pointer wrap. Squashes issued while blocked and while running show whether the unblock pulse depends on the prior state, and whether queued work is discarded rather than leaked.

// File: rtl/dec_stage_pkg.sv
`timescale 1ns/1ps
package dec_stage_pkg;

  localparam int NUM_STALL_SRC = 3;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RUN        = 3'd1,
    ST_BLOCKED    = 3'd2,
    ST_DRAINING   = 3'd3,
    ST_SQUASHING  = 3'd4
  } stage_state_e;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic outFromSkid;
    logic outFromFetch;
    logic pushAll;
    logic pushLeftover;
    logic clearSkid;
  } skid_ctrl_t;

endpackage

// File: rtl/dec_stage_datapath.sv
`timescale 1ns/1ps
module dec_stage_datapath
  import dec_stage_pkg::*;
#(
  parameter int IW    = 16,
  parameter int FW    = 4,
  parameter int DW    = 2,
  parameter int DEPTH = 10,
  parameter int LCW   = $clog2(FW + 1),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  skid_ctrl_t        ctrl,
  input  logic [FW-1:0]     fetchValid,
  input  logic [FW-1:0]     fetchSquashed,
  input  logic [FW*IW-1:0]  fetchInsts,
  output logic [LCW-1:0]    liveCount,
  output logic [CW-1:0]     skidCount,
  output logic [CW-1:0]     pushCount,
  output logic [CW-1:0]     popCount,
  output logic [DW-1:0]     renameValid,
  output logic [DW*IW-1:0]  renameInsts
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [FW-1:0]  live;
  logic [LCW-1:0] rank    [FW];
  logic [IW-1:0]  comp    [FW];
  logic [IW-1:0]  pushSrc [FW];
  logic [PW-1:0]  pushAddr[FW];
  logic [PW-1:0]  readAddr[DW];

  logic [IW-1:0]  mem [DEPTH];
  logic [PW-1:0]  rdPtr;
  logic [PW-1:0]  wrPtr;

  function automatic logic [PW-1:0] wrapAdd(input logic [PW-1:0] base,
                                            input int unsigned off);
    int unsigned s;
    s = int'(base) + off;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  assign live = fetchValid & ~fetchSquashed;

  // Rank each live slot among the live slots before it.
  always_comb begin
    logic [LCW-1:0] acc;
    acc = '0;
    for (int i = 0; i < FW; i++) begin
      rank[i] = acc;
      if (live[i]) acc = acc + LCW'(1);
    end
    liveCount = acc;
  end

  // Compact live slots to the low positions.
  always_comb begin
    for (int k = 0; k < FW; k++) begin
      comp[k] = '0;
      for (int i = 0; i < FW; i++) begin
        if (live[i] && (int'(rank[i]) == k)) comp[k] = fetchInsts[i*IW +: IW];
      end
    end
  end

  // Select what gets parked: everything, or what is left after DW.
  always_comb begin
    for (int k = 0; k < FW; k++) begin
      pushSrc[k] = comp[k];
      if (ctrl.pushLeftover) begin
        pushSrc[k] = '0;
        for (int i = 0; i < FW; i++) begin
          if (i == k + DW) pushSrc[k] = comp[i];
        end
      end
      pushAddr[k] = wrapAdd(wrPtr, k);
    end
  end

  always_comb begin
    if (ctrl.pushAll)           pushCount = CW'(liveCount);
    else if (ctrl.pushLeftover) pushCount = CW'(liveCount) - CW'(DW);
    else                        pushCount = '0;
    if (ctrl.outFromSkid)       popCount = (int'(skidCount) > DW) ? CW'(DW) : skidCount;
    else                        popCount = '0;
  end

  // Output lanes.
  always_comb begin
    for (int j = 0; j < DW; j++) begin
      readAddr[j] = wrapAdd(rdPtr, j);
      renameValid[j] = 1'b0;
      renameInsts[j*IW +: IW] = '0;
      if (ctrl.outFromSkid) begin
        renameValid[j] = (j < int'(skidCount));
        if (j < int'(skidCount)) renameInsts[j*IW +: IW] = mem[readAddr[j]];
      end else if (ctrl.outFromFetch) begin
        renameValid[j] = (j < int'(liveCount));
        if (j < int'(liveCount)) renameInsts[j*IW +: IW] = comp[j];
      end
    end
  end

  // Skid storage.
  always_ff @(posedge clk) begin
    if (!ctrl.clearSkid) begin
      for (int k = 0; k < FW; k++) begin
        if (k < int'(pushCount)) mem[pushAddr[k]] <= pushSrc[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctrl.clearSkid) begin
      rdPtr     <= '0;
      wrPtr     <= '0;
      skidCount <= '0;
    end else begin
      rdPtr     <= wrapAdd(rdPtr, int'(popCount));
      wrPtr     <= wrapAdd(wrPtr, int'(pushCount));
      skidCount <= skidCount - popCount + pushCount;
    end
  end

endmodule

// File: rtl/dec_stage_ctrl.sv
`timescale 1ns/1ps
module dec_stage_ctrl
  import dec_stage_pkg::*;
#(
  parameter int FW    = 4,
  parameter int DW    = 2,
  parameter int DEPTH = 10,
  parameter int LCW   = $clog2(FW + 1),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_STALL_SRC-1:0] stageBlock,
  input  logic [NUM_STALL_SRC-1:0] stageUnblock,
  input  logic                     commitSquash,
  input  logic                     robSquashing,
  input  logic                     anyValid,
  input  logic [LCW-1:0]           liveCount,
  input  logic [CW-1:0]            skidCount,
  output skid_ctrl_t               ctrl,
  output logic                     fetchBlock,
  output logic                     fetchUnblock
);

  stage_state_e              state, stateNext;
  logic [NUM_STALL_SRC-1:0]  stallQ, stallNext;
  logic                      stalled, wasHeld, squashNow;

  always_comb begin
    stallNext = (stallQ | stageBlock) & ~stageUnblock;
    stalled   = |stallNext;
    wasHeld   = (state == ST_BLOCKED) || (state == ST_DRAINING);
    squashNow = commitSquash || robSquashing;

    ctrl         = '0;
    stateNext    = state;
    fetchBlock   = 1'b0;
    fetchUnblock = 1'b0;

    if (squashNow) begin
      ctrl.clearSkid = 1'b1;
      stateNext      = ST_SQUASHING;
      fetchUnblock   = wasHeld;
    end else if (stalled) begin
      ctrl.pushAll = 1'b1;
      stateNext    = ST_BLOCKED;
      fetchBlock   = !wasHeld;
    end else if (wasHeld) begin
      ctrl.outFromSkid = 1'b1;
      ctrl.pushAll     = 1'b1;
      if ((int'(skidCount) <= DW) && (liveCount == '0)) begin
        stateNext    = ST_RUN;
        fetchUnblock = 1'b1;
      end else begin
        stateNext = ST_DRAINING;
      end
    end else begin
      ctrl.outFromFetch = 1'b1;
      if (int'(liveCount) > DW) begin
        ctrl.pushLeftover = 1'b1;
        stateNext         = ST_BLOCKED;
        fetchBlock        = 1'b1;
      end else if (anyValid || (state == ST_SQUASHING)) begin
        stateNext = ST_RUN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      stallQ <= '0;
    end else begin
      state  <= stateNext;
      stallQ <= stallNext;
    end
  end

endmodule

// File: rtl/dec_stage_top.sv
`timescale 1ns/1ps
module dec_stage_top
  import dec_stage_pkg::*;
#(
  parameter int IW          = 16,
  parameter int FW          = 4,
  parameter int DW          = 2,
  parameter int FETCH_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FW-1:0]     fetchValid,
  input  logic [FW-1:0]     fetchSquashed,
  input  logic [FW*IW-1:0]  fetchInsts,
  input  logic [2:0]        stageBlock,
  input  logic [2:0]        stageUnblock,
  input  logic              commitSquash,
  input  logic              robSquashing,
  output logic [DW-1:0]     renameValid,
  output logic [DW*IW-1:0]  renameInsts,
  output logic              fetchBlock,
  output logic              fetchUnblock
);

  localparam int SKID_DEPTH = FETCH_DELAY * FW + DW;
  localparam int LIVE_W     = $clog2(FW + 1);
  localparam int CNT_W      = $clog2(SKID_DEPTH + 1);

  skid_ctrl_t        ctrl;
  logic [LIVE_W-1:0] liveCount;
  logic [CNT_W-1:0]  skidCount, pushCount, popCount;

  dec_stage_ctrl #(.FW(FW), .DW(DW), .DEPTH(SKID_DEPTH), .LCW(LIVE_W), .CW(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .stageBlock(stageBlock), .stageUnblock(stageUnblock),
    .commitSquash(commitSquash), .robSquashing(robSquashing),
    .anyValid(|fetchValid), .liveCount(liveCount), .skidCount(skidCount),
    .ctrl(ctrl), .fetchBlock(fetchBlock), .fetchUnblock(fetchUnblock)
  );

  dec_stage_datapath #(.IW(IW), .FW(FW), .DW(DW), .DEPTH(SKID_DEPTH), .LCW(LIVE_W), .CW(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
    .fetchValid(fetchValid), .fetchSquashed(fetchSquashed), .fetchInsts(fetchInsts),
    .liveCount(liveCount), .skidCount(skidCount),
    .pushCount(pushCount), .popCount(popCount),
    .renameValid(renameValid), .renameInsts(renameInsts)
  );

endmodule

// File: rtl/dec_stage_checks.sv
`timescale 1ns/1ps
module dec_stage_checks #(
  parameter int DW    = 2,
  parameter int DEPTH = 10,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          commitSquash,
  input logic          robSquashing,
  input logic          fetchBlock,
  input logic          fetchUnblock,
  input logic [DW-1:0] renameValid,
  input logic [CW-1:0] skidCount,
  input logic [CW-1:0] pushCount,
  input logic [CW-1:0] popCount
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(skidCount) - int'(popCount) + int'(pushCount)) <= DEPTH); // R10

  AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((renameValid + 1'b1) & renameValid) == '0); // R2

  AST_BLOCK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fetchBlock |=> !fetchBlock); // R4

  AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (commitSquash || robSquashing) |-> (renameValid == '0 && !fetchBlock)); // R8

  AST_SQUASH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (commitSquash || robSquashing) |=> (skidCount == '0)); // R8

  AST_UNBLOCK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchUnblock && !commitSquash && !robSquashing) |=> (skidCount == '0)); // R7

endmodule

bind dec_stage_top dec_stage_checks #(.DW(DW), .DEPTH(SKID_DEPTH), .CW(CNT_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .commitSquash(commitSquash), .robSquashing(robSquashing),
  .fetchBlock(fetchBlock), .fetchUnblock(fetchUnblock), .renameValid(renameValid),
  .skidCount(skidCount), .pushCount(pushCount), .popCount(popCount)
);

// File: tb/dec_stage_top_bench.sv
`timescale 1ns/1ps
module dec_stage_top_bench;

  localparam int IW = 16;
  localparam int FW = 4;
  localparam int DW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [FW-1:0]    fetchValid = '0;
  logic [FW-1:0]    fetchSquashed = '0;
  logic [FW*IW-1:0] fetchInsts = '0;
  logic [2:0]       stageBlock = '0;
  logic [2:0]       stageUnblock = '0;
  logic             commitSquash = 1'b0;
  logic             robSquashing = 1'b0;
  logic [DW-1:0]    renameValid;
  logic [DW*IW-1:0] renameInsts;
  logic             fetchBlock;
  logic             fetchUnblock;

  always #10 clk = ~clk;

  dec_stage_top #(.IW(IW), .FW(FW), .DW(DW), .FETCH_DELAY(2)) u_dec_stage_top (
    .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid), .fetchSquashed(fetchSquashed),
    .fetchInsts(fetchInsts), .stageBlock(stageBlock), .stageUnblock(stageUnblock),
    .commitSquash(commitSquash), .robSquashing(robSquashing),
    .renameValid(renameValid), .renameInsts(renameInsts),
    .fetchBlock(fetchBlock), .fetchUnblock(fetchUnblock)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [IW-1:0] expQ[$];
  logic [IW-1:0] nextTag = 16'h0100;

  bit    armed = 0;
  int    expN;
  bit    expB, expU;
  string expReq;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Present a fetch group; keep=1 queues live slots as expected output.
  task automatic give(int n, logic [FW-1:0] sqMask, bit keep);
    for (int i = 0; i < FW; i++) begin
      fetchValid[i] = (i < n);
      fetchSquashed[i] = sqMask[i];
      fetchInsts[i*IW +: IW] = nextTag;
      if (i < n && !sqMask[i] && keep) expQ.push_back(nextTag);
      nextTag = nextTag + 1'b1;
    end
  endtask

  task automatic cyc(int n, bit b, bit u, string req);
    expN = n; expB = b; expU = u; expReq = req; armed = 1;
    @(posedge clk);
    @(negedge clk);
    fetchValid = '0; fetchSquashed = '0; stageBlock = '0; stageUnblock = '0;
    commitSquash = 1'b0; robSquashing = 1'b0;
  endtask

  // Monitor: compare sampled outputs against the scoreboard.
  always @(negedge clk) begin
    #5;
    if (armed && !finished) begin
      int cnt;
      cnt = 0;
      for (int j = 0; j < DW; j++) if (renameValid[j]) cnt++;
      check(cnt == expN, expReq, "lane count", cnt, expN);
      for (int j = 0; j < DW; j++) begin
        if (renameValid[j]) begin
          if (expQ.size() == 0) check(1'b0, expReq, "unexpected inst", int'(renameInsts[j*IW +: IW]), -1);
          else begin
            logic [IW-1:0] e;
            e = expQ.pop_front();
            check(renameInsts[j*IW +: IW] == e, expReq, "inst order", int'(renameInsts[j*IW +: IW]), int'(e));
          end
        end
      end
      check(fetchBlock == expB, expReq, "fetchBlock", int'(fetchBlock), int'(expB));
      check(fetchUnblock == expU, expReq, "fetchUnblock", int'(fetchUnblock), int'(expU));
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the ports
    #5;
    check(renameValid == '0, "R1", "renameValid", int'(renameValid), 0);
    check(!fetchBlock && !fetchUnblock, "R1", "pulses", int'({fetchBlock, fetchUnblock}), 0);
    @(negedge clk);
    cyc(0, 0, 0, "R11");                       // idle, nothing offered
    give(2, 4'b0000, 1); cyc(2, 0, 0, "R2");   // plain pass-through
    give(4, 4'b0110, 1); cyc(2, 0, 0, "R2");   // squashed holes skipped
    give(3, 4'b0000, 1); cyc(2, 1, 0, "R5");   // one left over
    cyc(1, 0, 1, "R7");                        // drain one, release fetch
    cyc(0, 0, 0, "R11");
    // Sticky stall from execute
    stageBlock = 3'b010; give(4, 4'b0000, 1); cyc(0, 1, 0, "R3");
    give(4, 4'b0000, 1); cyc(0, 0, 0, "R4");
    stageBlock = 3'b001; stageUnblock = 3'b010; cyc(0, 0, 0, "R3");
    stageUnblock = 3'b001; give(2, 4'b0000, 1); cyc(2, 0, 0, "R6");
    cyc(2, 0, 0, "R6");
    cyc(2, 0, 0, "R6");
    cyc(2, 0, 0, "R6");
    cyc(2, 0, 1, "R7");
    give(1, 4'b0000, 1); cyc(1, 0, 0, "R7");   // direct again
    // Re-stall while draining: no second block pulse
    stageBlock = 3'b100; give(4, 4'b0000, 1); cyc(0, 1, 0, "R4");
    stageUnblock = 3'b100; cyc(2, 0, 0, "R6");
    stageBlock = 3'b100; cyc(0, 0, 0, "R4");
    stageUnblock = 3'b100; cyc(2, 0, 1, "R7");
    // Same-cycle set and clear: clear wins
    stageBlock = 3'b001; stageUnblock = 3'b001; give(2, 4'b0000, 1); cyc(2, 0, 0, "R3");
    // Squash while blocked
    stageBlock = 3'b010; give(4, 4'b0000, 1); cyc(0, 1, 0, "R3");
    expQ.delete();
    commitSquash = 1'b1; stageUnblock = 3'b010; give(4, 4'b0000, 0); cyc(0, 0, 1, "R8");
    robSquashing = 1'b1; give(3, 4'b0000, 0); cyc(0, 0, 0, "R9");
    give(3, 4'b0000, 1); cyc(2, 1, 0, "R9");
    cyc(1, 0, 1, "R7");
    // Fill the skid FIFO to capacity, then drain across the wrap
    stageBlock = 3'b001; give(4, 4'b0000, 1); cyc(0, 1, 0, "R10");
    give(4, 4'b0000, 1); cyc(0, 0, 0, "R10");
    give(2, 4'b0000, 1); cyc(0, 0, 0, "R10");
    stageUnblock = 3'b001; cyc(2, 0, 0, "R10");
    cyc(2, 0, 0, "R10");
    cyc(2, 0, 0, "R10");
    cyc(2, 0, 0, "R10");
    cyc(2, 0, 1, "R10");
    // Squash while running: no unblock pulse
    commitSquash = 1'b1; give(2, 4'b0000, 0); cyc(0, 0, 0, "R8");
    cyc(0, 0, 0, "R9");
    give(1, 4'b0000, 1); cyc(1, 0, 0, "R9");
    armed = 0;
    check(expQ.size() == 0, "R6", "undelivered", expQ.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule